// File: doc/BRIEF.md
# Counter-form predicate decoder

This block turns a 16-bit predicate written in counter form into the three numbers an execution lane needs: how many vector elements are governed by the predicate, whether that run is counted from the top of the vector instead of from element zero, and a log2 element stride. It takes the vector length in bytes and the vector element size as well. The predicate carries its own element size, given by the position of its lowest set bit among the four low bits. When the predicate element size and the vector element size differ, the decoder adjusts the count arithmetically: it rounds the count up when predicate elements are narrower, and it scales the count and reports a stride when they are wider. It never builds the long bit-per-byte predicate to do this.

As a side output the block also produces that bit-per-byte lane mask, for consumers that want it. The mask is derived from the raw predicate-domain count, so it matches what a full bit expansion would give. The result passes through one output register stage with a valid/ready handshake. The upstream side may offer a new request in the same cycle the downstream side takes the held result. While the held result is not taken, `in_ready` stays low and the outputs do not move.

Top module: `pcnt_decoder`

## Requirements
- R1: If bits 3:0 of the predicate word are all zero, the result has count 0, invert 0, stride 0 and an all-zero lane mask.
- R2: The predicate element size p is the number of trailing zero bits of the predicate word (0 to 3). The raw count is (word AND ((P << 3) - 1)) >> (p + 1), where P is the smallest power of two that is at least the vector length in bytes. When p equals the vector element size v (0 to 3 for 8, 16, 32, 64 bits), the count output is the raw count and the stride is 0.
- R3: For a word with a nonzero low nibble, the invert output equals bit 15 of the word.
- R4: When p < v, the count is the raw count divided by 2^(v-p), rounded up, and the stride is 0.
- R5: When p > v, the count is the raw count multiplied by 2^(p-v), and the stride equals p - v.
- R6: With invert clear, mask byte b (b below the vector length) is set when its element's first byte f = (b >> v) << v is a multiple of 2^p and f >> p is below the raw count. All bytes of one element share one value.
- R7: With invert set, the rule of R6 applies except that f >> p must be at least (length >> p) minus the raw count; when the raw count reaches length >> p, every aligned element is active.
- R8: Mask bytes at indices at or above the vector length are 0. The length is a multiple of 16 from 16 to VL_MAX bytes.
- R9: `in_ready` is high when no result is held or `out_ready` is high. An accepted request shows on the outputs with `out_valid` after one clock edge. A held result that is not taken stays unchanged.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_pred | input | 16 | Counter-form predicate word |
| in_vlen | input | 9 | Vector length in bytes |
| in_vesz | input | 2 | Vector element size code |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream takes the held result |
| out_count | output | 10 | Active element count in vector elements |
| out_invert | output | 1 | Count taken from the top of the vector |
| out_stride | output | 2 | Log2 element stride |
| out_mask | output | 256 | Per-byte lane mask |

## Verification
Draining a held result and accepting a new request can happen on the same clock edge. The bench forces this case by holding `out_ready` low until a second request is waiting, then raising it. It checks that the first result stayed frozen while stalled, that the second result appears one edge after the release with nothing lost or duplicated, and that `out_valid` falls once that result is taken. The arithmetic count path and the mask path also produce their results for the same request. The bench checks both, for every pairing of predicate and vector element sizes, against a reference that builds the full bit expansion.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int unsigned PRED_W  = 16;
  localparam int unsigned INV_BIT = 15;
  localparam int unsigned ESZ_W   = 2;
  typedef logic [ESZ_W-1:0] esz_t;
endpackage

// File: rtl/pcnt_field_decode.sv
module pcnt_field_decode
  import pcnt_pkg::*;
#(
  parameter int unsigned VL_MAX = 256,
  localparam int unsigned LW = $clog2(VL_MAX) + 1,
  localparam int unsigned CW = $clog2(VL_MAX) + 2
) (
  input  logic [PRED_W-1:0] pred,
  input  logic [LW-1:0]     vlen,
  input  esz_t              vesz,
  output logic              nz,
  output esz_t              pesz,
  output logic [CW-1:0]     raw,
  output logic [CW-1:0]     count,
  output logic              invert,
  output esz_t              stride
);
  logic [LW-1:0]     p2;
  logic [LW+2:0]     lenmask;
  logic [PRED_W-1:0] masked;
  logic [PRED_W-1:0] shifted;
  logic [2:0]        sh1;
  esz_t              dsh;
  logic [CW-1:0]     trunc;

  always_comb begin
    nz = |pred[3:0];
    // trailing-zero count over the low nibble
    if (pred[0])      pesz = 2'd0;
    else if (pred[1]) pesz = 2'd1;
    else if (pred[2]) pesz = 2'd2;
    else              pesz = 2'd3;
    // next power of two of the vector length
    p2 = LW'(1);
    for (int i = 0; i < int'(LW); i++) begin
      if (p2 < vlen) p2 = p2 << 1;
    end
    lenmask = {p2, 3'b000} - (LW+3)'(1);
    masked  = pred & PRED_W'(lenmask);
    sh1     = {1'b0, pesz} + 3'd1;
    shifted = masked >> sh1;
    raw     = CW'(shifted);
  end

  always_comb begin
    count  = '0;
    stride = '0;
    invert = 1'b0;
    dsh    = '0;
    trunc  = '0;
    if (nz) begin
      invert = pred[INV_BIT];
      if (vesz > pesz) begin
        dsh   = vesz - pesz;
        trunc = raw >> dsh;
        count = trunc + CW'(raw != (trunc << dsh));
      end else if (pesz > vesz) begin
        dsh    = pesz - vesz;
        count  = raw << dsh;
        stride = dsh;
      end else begin
        count = raw;
      end
    end
  end
endmodule

// File: rtl/pcnt_mask_expand.sv
module pcnt_mask_expand
  import pcnt_pkg::*;
#(
  parameter int unsigned VL_MAX = 256,
  localparam int unsigned LW = $clog2(VL_MAX) + 1,
  localparam int unsigned CW = $clog2(VL_MAX) + 2
) (
  input  logic              nz,
  input  logic              invert,
  input  esz_t              pesz,
  input  esz_t              vesz,
  input  logic [CW-1:0]     raw,
  input  logic [LW-1:0]     vlen,
  output logic [VL_MAX-1:0] mask
);
  logic [LW-1:0] np;
  logic [CW-1:0] lo;
  logic [LW-1:0] amask;

  always_comb begin
    np    = vlen >> pesz;
    lo    = (CW'(np) <= raw) ? '0 : CW'(np) - raw;
    amask = (LW'(1) << pesz) - LW'(1);
  end

  for (genvar b = 0; b < int'(VL_MAX); b++) begin : g_lane
    logic [LW-1:0] first;
    logic [CW-1:0] pj;
    logic          act;
    assign first = (LW'(b) >> vesz) << vesz;
    assign pj    = CW'(first >> pesz);
    assign act   = invert ? (pj >= lo) : (pj < raw);
    assign mask[b] = nz && (LW'(b) < vlen) && ((first & amask) == '0) && act;
  end
endmodule

// File: rtl/pcnt_out_reg.sv
module pcnt_out_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/pcnt_decoder.sv
module pcnt_decoder
  import pcnt_pkg::*;
#(
  parameter int unsigned VL_MAX = 256,
  localparam int unsigned LW = $clog2(VL_MAX) + 1,
  localparam int unsigned CW = $clog2(VL_MAX) + 2,
  localparam int unsigned DW = CW + 1 + ESZ_W + VL_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PRED_W-1:0] in_pred,
  input  logic [LW-1:0]     in_vlen,
  input  logic [ESZ_W-1:0]  in_vesz,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW-1:0]     out_count,
  output logic              out_invert,
  output logic [ESZ_W-1:0]  out_stride,
  output logic [VL_MAX-1:0] out_mask
);
  logic              nz, invert;
  esz_t              pesz, stride;
  logic [CW-1:0]     raw, count;
  logic [VL_MAX-1:0] mask;
  logic [DW-1:0]     d_in, d_out;

  pcnt_field_decode #(.VL_MAX(VL_MAX)) u_dec (
    .pred(in_pred), .vlen(in_vlen), .vesz(in_vesz),
    .nz(nz), .pesz(pesz), .raw(raw), .count(count),
    .invert(invert), .stride(stride)
  );

  pcnt_mask_expand #(.VL_MAX(VL_MAX)) u_exp (
    .nz(nz), .invert(invert), .pesz(pesz), .vesz(in_vesz),
    .raw(raw), .vlen(in_vlen), .mask(mask)
  );

  assign d_in = {count, invert, stride, mask};

  pcnt_out_reg #(.DW(DW)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(d_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(d_out)
  );

  assign {out_count, out_invert, out_stride, out_mask} = d_out;
endmodule

// File: rtl/pcnt_decoder_chk.sv
module pcnt_decoder_chk #(
  parameter int unsigned VL_MAX = 256,
  localparam int unsigned LW = $clog2(VL_MAX) + 1,
  localparam int unsigned CW = $clog2(VL_MAX) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_pred,
  input logic [LW-1:0]     in_vlen,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CW-1:0]     out_count,
  input logic              out_invert,
  input logic [1:0]        out_stride,
  input logic [VL_MAX-1:0] out_mask
);
  p_zero_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pred[3:0] == 4'd0) |=>
      (out_count == '0 && !out_invert && out_stride == 2'd0 && out_mask == '0));

  p_invert_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pred[3:0] != 4'd0) |=> (out_invert == $past(in_pred[15])));

  p_byte_pred_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pred[0]) |=> (out_stride == 2'd0));

  p_empty_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == '0 && !out_invert) |-> (out_mask == '0));

  p_tail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_vlen == LW'(16)) |=> (out_mask[VL_MAX-1:16] == '0));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count) && $stable(out_mask)
                                   && $stable(out_invert) && $stable(out_stride)));
endmodule

bind pcnt_decoder pcnt_decoder_chk #(.VL_MAX(VL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pred(in_pred), .in_vlen(in_vlen), .out_valid(out_valid), .out_ready(out_ready),
  .out_count(out_count), .out_invert(out_invert), .out_stride(out_stride), .out_mask(out_mask)
);

// File: tb/test_pcnt_decoder.sv
module test_pcnt_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_pred = '0;
  logic [8:0]   in_vlen = 9'd16;
  logic [1:0]   in_vesz = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [9:0]   out_count;
  logic         out_invert;
  logic [1:0]   out_stride;
  logic [255:0] out_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcnt_decoder i_pcnt_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pred(in_pred), .in_vlen(in_vlen), .in_vesz(in_vesz),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
    .out_invert(out_invert), .out_stride(out_stride), .out_mask(out_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_p(input logic [15:0] w);
    for (int i = 0; i < 4; i++) if (w[i]) return i;
    return 0;
  endfunction

  function automatic int ref_raw(input logic [15:0] w, input int vl);
    int p2 = 1;
    while (p2 < vl) p2 = p2 * 2;
    return (int'(w) & (p2 * 8 - 1)) >> (ref_p(w) + 1);
  endfunction

  function automatic int ref_cnt(input logic [15:0] w, input int vl, input int v);
    int p = ref_p(w);
    int c = ref_raw(w, vl);
    if (w[3:0] == 4'd0) return 0;
    if (p < v) c = (c + (1 << (v - p)) - 1) / (1 << (v - p));
    else if (p > v) c = c * (1 << (p - v));
    return c;
  endfunction

  function automatic int ref_stride(input logic [15:0] w, input int v);
    if (w[3:0] == 4'd0) return 0;
    return (ref_p(w) > v) ? ref_p(w) - v : 0;
  endfunction

  // full bit-per-byte predicate expansion, then per-element sampling
  function automatic logic [255:0] ref_mask(input logic [15:0] w, input int vl, input int v);
    logic [255:0] pb = '0;
    logic [255:0] m = '0;
    int p = ref_p(w);
    int c = ref_raw(w, vl);
    int np = vl >> p;
    if (w[3:0] == 4'd0) return '0;
    for (int j = 0; j < np; j++)
      pb[j << p] = w[15] ? (j >= np - c) : (j < c);
    for (int b = 0; b < vl; b++)
      m[b] = pb[(b >> v) << v];
    return m;
  endfunction

  task automatic drive(input logic [15:0] w, input int vl, input int v);
    @(negedge clk);
    in_pred = w; in_vlen = 9'(vl); in_vesz = 2'(v); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(input logic [15:0] w, input int vl, input int v, input string req);
    int ec = ref_cnt(w, vl, v);
    int es = ref_stride(w, v);
    logic [255:0] em = ref_mask(w, vl, v);
    logic ei = (w[3:0] != 4'd0) && w[15];
    chk(out_count == 10'(ec), {req, " count"}, 256'(out_count), 256'(ec));
    chk(out_stride == 2'(es), {req, " stride"}, 256'(out_stride), 256'(es));
    chk(out_invert == ei, {req, " invert"}, 256'(out_invert), 256'(ei));
    chk(out_mask == em, {req, " mask"}, out_mask, em);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10 out_valid", 256'(out_valid), 256'(0));
    chk(in_ready == 1'b1, "R10 in_ready", 256'(in_ready), 256'(1));
  endtask

  task automatic t_zero_nibble;
    logic [15:0] pats[4] = '{16'hFFF0, 16'h8010, 16'h0000, 16'h7FF0};
    foreach (pats[k]) begin
      drive(pats[k], 64, k % 4);
      compare(pats[k], 64, k % 4, "R1");
    end
  endtask

  task automatic t_equal_sizes;
    // p = v = 1, vl 48 -> P=64, mask 511; bits above it are discarded
    drive(16'hFE26, 48, 1);
    compare(16'hFE26, 48, 1, "R2 R3");
    chk(out_count == 10'((16'hFE26 & 16'h01FF) >> 2), "R2 raw", 256'(out_count), 256'((16'hFE26 & 16'h01FF) >> 2));
  endtask

  task automatic t_sweep;
    int vls[5] = '{16, 48, 128, 144, 256};
    int raws[6] = '{0, 1, 3, 7, 37, 1023};
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 4; v++)
        foreach (vls[i])
          foreach (raws[r])
            for (int inv = 0; inv < 2; inv++) begin
              logic [15:0] w;
              string req;
              w = 16'(((raws[r] << (p + 1)) | (1 << p)) & 16'h7FFF) | 16'(inv << 15);
              req = (p < v) ? "R4" : (p > v) ? "R5" : "R2";
              req = {req, inv ? " R7 R8" : " R6 R8"};
              drive(w, vls[i], v);
              compare(w, vls[i], v, req);
            end
  endtask

  task automatic t_invert_edges;
    // raw count beyond the predicate element total: every aligned element active
    drive(16'h87FE, 32, 0);
    compare(16'h87FE, 32, 0, "R7 full");
    // wider predicate elements, invert, vector bytes
    drive(16'h8018, 128, 0);
    compare(16'h8018, 128, 0, "R7 stride");
  endtask

  task automatic t_backpressure;
    logic [15:0] wa = 16'h0035;
    logic [15:0] wb = 16'h8044;
    @(negedge clk);
    out_ready = 1'b0;
    in_pred = wa; in_vlen = 9'd64; in_vesz = 2'd2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_pred = wb; in_vlen = 9'd96; in_vesz = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 stalled ready", 256'(in_ready), 256'(0));
    chk(out_valid == 1'b1, "R9 held valid", 256'(out_valid), 256'(1));
    compare(wa, 64, 2, "R9 held");
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 swap valid", 256'(out_valid), 256'(1));
    compare(wb, 96, 0, "R9 swap");
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", 256'(out_valid), 256'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_nibble();
    t_equal_sizes();
    t_sweep();
    t_invert_edges();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule